// File: doc/BRIEF.md
# Power-On Dual Reset Sequencer

This block produces two active-low reset outputs from a power-good input and a clock-stable indication. One output is a global reset. The other is a bus reset. Both outputs are held asserted from the moment power-good is low. Once power-good is high, the global reset is kept asserted for a minimum number of reference-clock cycles and is then released.

The bus reset is released only after the global reset has been released. It also waits until the bus clock has been reported stable for a minimum number of consecutive reference cycles. If the clock-stable indication drops during this qualification window, the window starts again from zero. A done flag goes high one cycle after the bus reset is released. All outputs come straight from flip-flops, so they cannot glitch.

Both minimum hold times are parameters counted in reference-clock cycles, that is, the reference frequency multiplied by the required time. If power-good is lost, the whole sequence returns to its initial state.

Top module: `pwr_rst_sequencer`

## Requirements
- R1: While `pwr_good` is sampled low at a rising edge, `glob_rst_n`, `bus_rst_n` and `seq_done` are all 0 after that edge.
- R2: Counting the rising edges at which `pwr_good` is high, `glob_rst_n` stays 0 through edge number GLOBAL_HOLD_CYC and becomes 1 at edge GLOBAL_HOLD_CYC+1.
- R3: `bus_rst_n` is never 1 while `glob_rst_n` is 0.
- R4: After the global release, `bus_rst_n` becomes 1 at the first rising edge where `clk_stable` is high and has been high at the previous STABLE_HOLD_CYC rising edges without a break. This requires STABLE_HOLD_CYC+1 consecutive high samples in total.
- R5: A low sample of `clk_stable` before the bus release restarts the stability count from zero.
- R6: One rising edge with `pwr_good` low drives all three outputs to 0 at once. The sequence then starts again from its initial state.
- R7: `seq_done` becomes 1 exactly one cycle after `bus_rst_n` becomes 1.
- R8: After the bus release, a low `clk_stable` has no effect. All outputs stay 1 while `pwr_good` stays high.
- R9: Stability is counted while the global reset is still held. If `clk_stable` has been high long enough, `bus_rst_n` is released one edge after `glob_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| pwr_good | input | 1 | Supply good; low acts as the synchronous reset of the whole sequence |
| clk_stable | input | 1 | High while the bus clock is reported stable |
| glob_rst_n | output | 1 | Global reset, active low, registered |
| bus_rst_n | output | 1 | Bus reset, active low, registered |
| seq_done | output | 1 | High from one cycle after the bus release |

## Verification
The assertions check four properties on every cycle:
- the release order of the two resets;
- that the bus release is preceded by a high clock-stable sample;
- the one-cycle lag of the done flag;
- that a released bus reset stays released, and that the counters never run past their limits.

Only the bench's reference model can show the exact release cycles. It also covers the restart of the stability window after a dropout, the early qualification during the global hold, and the full restart after power-good is lost.

// File: rtl/rst_seq_pkg.sv
// Package: shared state encoding for the power-on reset sequencer.
// Assumes: three states are enough; the ordering is the release order.
package rst_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD_ALL = 2'd0,   // both resets asserted, global timer running
        SEQ_QUALIFY  = 2'd1,   // global released, waiting for stable bus clock
        SEQ_RELEASED = 2'd2    // both released
    } seq_state_t;
endpackage

// File: rtl/rst_hold_counter.sv
// Module: saturating hold-time counter.
// Counts enabled cycles up to LIMIT and stays there; reports when LIMIT is held.
// Assumes: LIMIT >= 1; rst_n is synchronous, active low; restart has priority
// over enable.
module rst_hold_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIMIT_W = W'(LIMIT);

    logic [W-1:0] cnt;

    // Purpose: count enabled cycles, clear on reset or restart, saturate at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (enable && (cnt != LIMIT_W)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: flag that the full hold time has been counted.
    always_comb begin
        reached = (cnt == LIMIT_W);
    end

    // R2 / R4: the counter never passes its limit.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_W);

    // R5: a restart always leaves the counter at zero.
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/rst_seq_fsm.sv
// Module: release-order state machine with registered reset outputs.
// Moves from full hold to qualification when the global timer expires. Moves
// to released when the stability timer has expired and the clock is still
// stable. Outputs are registered from the next state, so they change together
// with the state.
// Assumes: rst_n (power good) is synchronous and active low.
module rst_seq_fsm
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       glob_reached,
    input  logic       stab_reached,
    input  logic       clk_stable,
    output seq_state_t state_o,
    output logic       glob_rst_n,
    output logic       bus_rst_n,
    output logic       seq_done
);
    seq_state_t state_q, state_d;

    // Purpose: next-state decision; the order of the releases is fixed.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HOLD_ALL: if (glob_reached)               state_d = SEQ_QUALIFY;
            SEQ_QUALIFY:  if (stab_reached && clk_stable) state_d = SEQ_RELEASED;
            SEQ_RELEASED: state_d = SEQ_RELEASED;
            default:      state_d = SEQ_HOLD_ALL;
        endcase
    end

    // Purpose: state and glitch-free output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_HOLD_ALL;
            glob_rst_n <= 1'b0;
            bus_rst_n  <= 1'b0;
            seq_done   <= 1'b0;
        end else begin
            state_q    <= state_d;
            glob_rst_n <= (state_d != SEQ_HOLD_ALL);
            bus_rst_n  <= (state_d == SEQ_RELEASED);
            seq_done   <= bus_rst_n;
        end
    end

    // Purpose: expose the state to the counter controls.
    always_comb begin
        state_o = state_q;
    end

    // R7: done rises only one cycle after the bus release.
    a_r7_done_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(bus_rst_n));

    // R2: the global release needs an expired global timer.
    a_r2_glob_timer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_rst_n) |-> $past(glob_reached));
endmodule

// File: rtl/pwr_rst_sequencer.sv
// Module: power-on dual reset sequencer (top).
// Holds a global and a bus reset from power-good low. Releases the global
// reset after GLOBAL_HOLD_CYC reference cycles. Releases the bus reset after
// that, once the bus clock has been stable for STABLE_HOLD_CYC cycles.
// Assumes: clk is free-running; pwr_good and clk_stable are synchronous to clk.
module pwr_rst_sequencer #(
    parameter int GLOBAL_HOLD_CYC = 200_000,  // 2 ms at 100 MHz
    parameter int STABLE_HOLD_CYC = 10_000    // 100 us at 100 MHz
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic clk_stable,
    output logic glob_rst_n,
    output logic bus_rst_n,
    output logic seq_done
);
    import rst_seq_pkg::*;

    seq_state_t state;
    logic       glob_reached;
    logic       stab_reached;
    logic       glob_en;
    logic       stab_en;
    logic       stab_restart;

    // Purpose: the global timer runs only during the full hold; the stability
    // timer runs until release and restarts on any unstable sample.
    always_comb begin
        glob_en      = (state == SEQ_HOLD_ALL);
        stab_en      = clk_stable && (state != SEQ_RELEASED);
        stab_restart = !clk_stable && (state != SEQ_RELEASED);
    end

    rst_hold_counter #(.LIMIT(GLOBAL_HOLD_CYC)) u_glob_cnt (
        .clk     (clk),
        .rst_n   (pwr_good),
        .enable  (glob_en),
        .restart (1'b0),
        .reached (glob_reached)
    );

    rst_hold_counter #(.LIMIT(STABLE_HOLD_CYC)) u_stab_cnt (
        .clk     (clk),
        .rst_n   (pwr_good),
        .enable  (stab_en),
        .restart (stab_restart),
        .reached (stab_reached)
    );

    rst_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (pwr_good),
        .glob_reached (glob_reached),
        .stab_reached (stab_reached),
        .clk_stable   (clk_stable),
        .state_o      (state),
        .glob_rst_n   (glob_rst_n),
        .bus_rst_n    (bus_rst_n),
        .seq_done     (seq_done)
    );

    // R3: the bus reset is never released ahead of the global reset.
    a_r3_release_order: assert property (@(posedge clk) disable iff (!pwr_good)
        bus_rst_n |-> glob_rst_n);

    // R4: a bus release is always preceded by a stable clock sample.
    a_r4_stable_before_bus: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(bus_rst_n) |-> $past(clk_stable));

    // R6: in the first cycle after power-good returns, every output is reset.
    a_r6_restart_clean: assert property (@(posedge clk) disable iff (!pwr_good)
        !$past(pwr_good) |-> (!glob_rst_n && !bus_rst_n && !seq_done));

    // R8: a released bus reset stays released while power is good.
    a_r8_bus_sticky: assert property (@(posedge clk) disable iff (!pwr_good)
        bus_rst_n |=> bus_rst_n);
endmodule

// File: tb/pwr_rst_sequencer_bench.sv
module pwr_rst_sequencer_bench;
    localparam int G = 20;
    localparam int S = 8;

    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic clk_stable = 1'b0;
    logic glob_rst_n, bus_rst_n, seq_done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference model
    int  m_gcnt = 0, m_scnt = 0, m_phase = 0;
    bit  m_glob = 0, m_bus = 0, m_done = 0;

    always #5 clk = ~clk;

    pwr_rst_sequencer #(.GLOBAL_HOLD_CYC(G), .STABLE_HOLD_CYC(S)) u_pwr_rst_sequencer (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .clk_stable (clk_stable),
        .glob_rst_n (glob_rst_n),
        .bus_rst_n  (bus_rst_n),
        .seq_done   (seq_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: phase 0 hold all, 1 waiting for stable clock, 2 released
    always @(posedge clk) begin
        cycles++;
        if (!pwr_good) begin
            m_gcnt = 0; m_scnt = 0; m_phase = 0;
            m_glob = 0; m_bus = 0; m_done = 0;
        end else begin
            bit went_done;
            m_done = m_bus;
            went_done = (m_phase == 1) && (m_scnt >= S) && clk_stable;
            if (m_phase == 0 && m_gcnt >= G) m_phase = 1;
            else if (went_done) m_phase = 2;
            else if (m_phase == 0 && m_gcnt < G) m_gcnt++;
            if (m_phase != 2) begin
                if (!clk_stable) m_scnt = 0;
                else if (m_scnt < S) m_scnt++;
            end
            m_glob = (m_phase != 0);
            m_bus  = (m_phase == 2);
        end
    end

    // compare against the model each cycle, away from the active edge
    always @(negedge clk) begin
        if (cycles > 0) begin
            check(glob_rst_n === m_glob, cur_req, "model glob_rst_n", int'(glob_rst_n), int'(m_glob));
            check(bus_rst_n  === m_bus,  cur_req, "model bus_rst_n",  int'(bus_rst_n),  int'(m_bus));
            check(seq_done   === m_done, cur_req, "model seq_done",   int'(seq_done),   int'(m_done));
        end
    end

    // watchdog
    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        step(3);
        check(!glob_rst_n && !bus_rst_n && !seq_done, "R1", "all low in reset",
              int'({glob_rst_n, bus_rst_n, seq_done}), 0);

        // R2, R9, R7: stable clock from power-up
        cur_req = "R2";
        pwr_good = 1; clk_stable = 1;
        step(G);
        check(glob_rst_n == 0, "R2", "glob held at edge G", int'(glob_rst_n), 0);
        step(1);
        check(glob_rst_n == 1, "R2", "glob released at edge G+1", int'(glob_rst_n), 1);
        check(bus_rst_n == 0, "R3", "bus still held with glob", int'(bus_rst_n), 0);
        cur_req = "R9";
        step(1);
        check(bus_rst_n == 1, "R9", "bus one edge after glob", int'(bus_rst_n), 1);
        check(seq_done == 0, "R7", "done not yet", int'(seq_done), 0);
        cur_req = "R7";
        step(1);
        check(seq_done == 1, "R7", "done one cycle after bus", int'(seq_done), 1);

        // R8: unstable clock after release is ignored
        cur_req = "R8";
        clk_stable = 0;
        step(4);
        check(bus_rst_n == 1 && glob_rst_n == 1 && seq_done == 1, "R8",
              "outputs kept after release", int'({glob_rst_n, bus_rst_n, seq_done}), 7);

        // R6: power loss and restart
        cur_req = "R6";
        pwr_good = 0;
        step(1);
        check(!glob_rst_n && !bus_rst_n && !seq_done, "R6", "all low after power loss",
              int'({glob_rst_n, bus_rst_n, seq_done}), 0);
        pwr_good = 1;
        step(2);
        check(glob_rst_n == 0, "R6", "sequence restarted", int'(glob_rst_n), 0);

        // R4, R5: clock becomes stable late and drops once in the window
        cur_req = "R4";
        step(G + 2);
        check(glob_rst_n == 1 && bus_rst_n == 0, "R4", "bus waits for stable clock",
              int'({glob_rst_n, bus_rst_n}), 2);
        clk_stable = 1;
        step(S - 2);
        cur_req = "R5";
        clk_stable = 0;
        step(1);
        clk_stable = 1;
        step(S);
        check(bus_rst_n == 0, "R5", "count restarted after dropout", int'(bus_rst_n), 0);
        step(1);
        check(bus_rst_n == 1, "R4", "bus released after S+1 stable samples", int'(bus_rst_n), 1);
        step(2);
        check(seq_done == 1, "R7", "done after late release", int'(seq_done), 1);

        // R5 during global hold: dropout just before glob release delays bus
        cur_req = "R5";
        pwr_good = 0;
        step(2);
        pwr_good = 1; clk_stable = 1;
        step(G - 2);
        clk_stable = 0;
        step(1);
        clk_stable = 1;
        step(4);
        check(glob_rst_n == 1 && bus_rst_n == 0, "R5", "bus held after dropout in hold",
              int'({glob_rst_n, bus_rst_n}), 2);
        step(S);
        check(bus_rst_n == 1, "R4", "bus released after requalification", int'(bus_rst_n), 1);
        step(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule